// File: doc/BRIEF.md
# Fractional Tick Divider with First-Order Noise Shaping

This block divides a fast reference clock down to a one-cycle tick strobe. The division ratio has a 12-bit integer part and a 10-bit fraction measured in 1/1024ths. The block has two modes. In integer mode every output period is exactly the integer divisor and the fraction is ignored. In noise-shaped mode a 10-bit accumulator adds the fraction once per period. A carry out of that accumulator stretches the period by one reference cycle. The long-term rate then follows the full fractional ratio, and single periods jitter by one cycle. For example, a 19.2 MHz reference with divisor 19 and fraction 204 gives a tick rate of about 1 MHz, made of 19- and 20-cycle periods.

A small state machine controls the block. `ST_IDLE` holds the counter and accumulator at zero while `en` is low. When `en` is sampled high, the machine enters `ST_BASE` or `ST_LONG`: `ST_LONG` when the accumulator carries for the starting period, `ST_BASE` otherwise. Each time the counter expires, the machine moves again to `ST_BASE` or `ST_LONG` for the next period, again by the carry. From any state, a low `en` returns the machine to `ST_IDLE`. The divisor, fraction and mode are sampled only at period starts.

Top module: `frac_tick_div`

## Requirements
- R1: `tick` is 0 during reset and in every cycle that follows a clock edge that sampled `en` low.
- R2: With `mash_mode` = 0, every period (counted from the enabling edge, or from the cycle after a tick, through the next tick) lasts exactly the effective divisor, whatever `div_frac` holds; the accumulator is held at zero.
- R3: A `div_int` value of 0 or 1 is treated as 2 in both modes.
- R4: With `mash_mode` = 1, every period lasts either the effective divisor or the effective divisor plus one.
- R5: With `mash_mode` = 1, at each period start the 10-bit accumulator adds `div_frac`. The period is one cycle longer exactly when that addition carries past bit 9. Any 1024 consecutive such periods therefore contain exactly `div_frac` long ones.
- R6: `div_int`, `div_frac` and `mash_mode` are sampled only at a period start. A change during a period leaves that period's length unchanged and applies from the next period.
- R7: A low `en` clears the counter and the accumulator. After re-enabling, the sequence of long and short periods restarts as if from reset.
- R8: `tick` is never high in two consecutive cycles.
- R9: The full-scale setting (divisor 4095, fraction 1023) gives periods of 4095 and 4096 cycles without wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low clears counter and accumulator |
| mash_mode | input | 1 | 0 = integer division, 1 = first-order noise-shaped fraction |
| div_int | input | 12 | Integer divisor, values below 2 treated as 2 |
| div_frac | input | 10 | Fraction in units of 1/1024 |
| tick | output | 1 | One-cycle strobe in the last cycle of each period |

## Verification
The bench targets the cases where the carry decision and the period start can drift apart. It changes the divisor in the middle of a period: a design that samples the divisor continuously would shorten that period. It disables and re-enables with a fraction: a design that keeps a stale accumulator would shift the pattern of long periods. It runs 1024 periods and counts the long ones: a wrong carry width or a missed carry would give a count other than the fraction. It also drives divisors 0 and 1, which must behave as 2, and the full-scale setting, which must not wrap the 12-bit counter.

// File: rtl/frac_div_pkg.sv
`timescale 1ns/1ps
package frac_div_pkg;

    // Control states of the divider
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // disabled, counter and accumulator cleared
        ST_BASE = 2'd1,   // running a period of the plain divisor
        ST_LONG = 2'd2    // running a period stretched by one cycle
    } div_state_e;

endpackage

// File: rtl/frac_div_accum.sv
`timescale 1ns/1ps
module frac_div_accum #(
    parameter int FRAC_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              mash_on,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    // Sum with carry bit; the carry marks a stretched period
    assign sum   = {1'b0, acc_q} + {1'b0, frac};
    assign carry = mash_on & sum[FRAC_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear || !mash_on) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/frac_div_counter.sv
`timescale 1ns/1ps
module frac_div_counter #(
    parameter int INT_W   = 12,
    parameter int MIN_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             stretch,
    input  logic [INT_W-1:0] div_int,
    output logic             expired
);

    localparam logic [INT_W-1:0] MIN_V = INT_W'(MIN_DIV);

    logic [INT_W-1:0] cnt_q;
    logic [INT_W-1:0] eff_div;
    logic [INT_W:0]   reload;

    // Small divisors are raised to the minimum so a tick never repeats back to back
    assign eff_div = (div_int < MIN_V) ? MIN_V : div_int;
    assign reload  = {1'b0, eff_div} - {{INT_W{1'b0}}, 1'b1} + {{INT_W{1'b0}}, stretch};
    assign expired = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload[INT_W-1:0];
        end else if (!expired) begin
            cnt_q <= cnt_q - {{(INT_W-1){1'b0}}, 1'b1};
        end
    end

endmodule

// File: rtl/frac_div_fsm.sv
`timescale 1ns/1ps
module frac_div_fsm
    import frac_div_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic expired,
    input  logic carry,
    output logic start,
    output logic clear,
    output logic tick
);

    div_state_e state_q;
    div_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en) state_d = carry ? ST_LONG : ST_BASE;
            end
            ST_BASE, ST_LONG: begin
                if (!en)          state_d = ST_IDLE;
                else if (expired) state_d = carry ? ST_LONG : ST_BASE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        start = 1'b0;
        tick  = 1'b0;
        clear = !en;
        unique case (state_q)
            ST_IDLE: begin
                start = en;
            end
            ST_BASE, ST_LONG: begin
                tick  = expired;
                start = en && expired;
            end
            default: begin
                start = 1'b0;
                tick  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/frac_tick_div.sv
`timescale 1ns/1ps
module frac_tick_div #(
    parameter int INT_W   = 12,
    parameter int FRAC_W  = 10,
    parameter int MIN_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              mash_mode,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);

    logic start;
    logic clear;
    logic expired;
    logic carry;

    frac_div_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .expired (expired),
        .carry   (carry),
        .start   (start),
        .clear   (clear),
        .tick    (tick)
    );

    frac_div_accum #(.FRAC_W(FRAC_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .mash_on (mash_mode),
        .step    (start),
        .frac    (div_frac),
        .carry   (carry)
    );

    frac_div_counter #(.INT_W(INT_W), .MIN_DIV(MIN_DIV)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .load    (start),
        .stretch (carry),
        .div_int (div_int),
        .expired (expired)
    );

endmodule

// File: rtl/frac_tick_div_chk.sv
`timescale 1ns/1ps
module frac_tick_div_chk #(
    parameter int INT_W   = 12,
    parameter int MIN_DIV = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             mash_mode,
    input logic [INT_W-1:0] div_int,
    input logic             tick
);

    localparam logic [INT_W-1:0] MIN_V = INT_W'(MIN_DIV);

    logic [INT_W:0] gap;     // cycles into the current period
    logic [INT_W:0] div_at;  // effective divisor seen at the last boundary
    logic           mode_at; // mode seen at the last boundary
    logic           seen;    // a tick has occurred since enable

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap     <= '0;
            div_at  <= '0;
            mode_at <= 1'b0;
            seen    <= 1'b0;
        end else if (!en) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (tick) begin
            gap     <= {{INT_W{1'b0}}, 1'b1};
            seen    <= 1'b1;
            mode_at <= mash_mode;
            div_at  <= {1'b0, (div_int < MIN_V) ? MIN_V : div_int};
        end else begin
            gap <= gap + {{INT_W{1'b0}}, 1'b1};
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick);

    // R2 and R3: integer periods are exactly the clamped divisor
    assert_int_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && tick && !mode_at) |-> (gap == div_at));

    assert_mash_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && tick && mode_at) |-> (gap == div_at || gap == div_at + 1'b1));

    assert_single_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

bind frac_tick_div frac_tick_div_chk #(.INT_W(INT_W), .MIN_DIV(MIN_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .mash_mode (mash_mode),
    .div_int   (div_int),
    .tick      (tick)
);

// File: tb/frac_tick_div_test.sv
`timescale 1ns/1ps
module frac_tick_div_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic        mash_mode;
    logic [11:0] div_int;
    logic [9:0]  div_frac;
    logic        tick;

    frac_tick_div uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .mash_mode (mash_mode),
        .div_int   (div_int),
        .div_frac  (div_frac),
        .tick      (tick)
    );

    always #5 clk = ~clk;

    int    q_len[$];
    string q_tag[$];
    int    n_checks  = 0;
    int    n_fail    = 0;
    int    cyc_cnt   = 0;
    int    model_acc = 0;
    int    base_len  = 0;
    int    obs_long  = 0;
    bit    done      = 1'b0;
    logic  en_q      = 1'b0;
    logic  tick_prev = 1'b0;

    always @(posedge clk) en_q <= en;

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d, expected %0d", tag, got, exp);
        end
    endtask

    // Driver: computes expected period lengths from the requirements
    task automatic push_periods(input int d, input int f, input bit m, input int n, input string tag);
        int eff;
        eff = (d < 2) ? 2 : d;
        for (int i = 0; i < n; i++) begin
            int lg;
            if (m) begin
                int s;
                s = model_acc + f;
                lg = (s >= 1024) ? 1 : 0;
                model_acc = s % 1024;
            end else begin
                model_acc = 0;
                lg = 0;
            end
            q_len.push_back(eff + lg);
            q_tag.push_back(tag);
        end
    endtask

    task automatic drain();
        while (q_len.size() != 0) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic set_cfg(input int d, input int f, input bit m);
        div_int   = 12'(d);
        div_frac  = 10'(f);
        mash_mode = m;
    endtask

    // Monitor: measures each period and compares against the scoreboard
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                cyc_cnt = 0;
            end else if (!en_q) begin
                cyc_cnt = 0;
                check(tick == 1'b0, "R1 idle tick", int'(tick), 0);
            end else begin
                cyc_cnt++;
                if (tick) begin
                    check(tick_prev == 1'b0, "R8 back-to-back tick", 1, 0);
                    if (q_len.size() == 0) begin
                        check(1'b0, "R2 unexpected tick", cyc_cnt, 0);
                    end else begin
                        int    exp;
                        string tg;
                        exp = q_len.pop_front();
                        tg  = q_tag.pop_front();
                        check(cyc_cnt == exp, tg, cyc_cnt, exp);
                    end
                    if (cyc_cnt == base_len + 1) obs_long++;
                    cyc_cnt = 0;
                end
            end
            tick_prev = tick;
        end
    end

    initial begin
        rst_n = 1'b0;
        en    = 1'b0;
        set_cfg(19, 204, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(tick == 1'b0, "R1 reset tick", int'(tick), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;

        // R2: integer mode ignores the fraction
        push_periods(19, 204, 1'b0, 6, "R2 integer period");
        en = 1'b1;
        drain();

        // R6: change at a boundary applies to the next period
        set_cfg(7, 204, 1'b0);
        push_periods(7, 204, 1'b0, 5, "R6 boundary change");
        drain();

        // R6: mid-period change leaves the running period alone
        set_cfg(20, 0, 1'b0);
        push_periods(20, 0, 1'b0, 1, "R6 period before change");
        repeat (5) @(negedge clk);
        #1;
        set_cfg(9, 300, 1'b0);
        push_periods(9, 300, 1'b0, 3, "R6 after mid-period change");
        drain();

        // R3: divisors 0 and 1 behave as 2
        set_cfg(0, 0, 1'b0);
        push_periods(0, 0, 1'b0, 4, "R3 divisor 0");
        drain();
        set_cfg(1, 0, 1'b0);
        push_periods(1, 0, 1'b0, 4, "R3 divisor 1");
        drain();

        // R1: disabled output stays low
        en = 1'b0;
        model_acc = 0;
        repeat (4) @(negedge clk);
        #1;

        // R4 and R5: noise-shaped sequence from a cleared accumulator
        set_cfg(19, 204, 1'b1);
        push_periods(19, 204, 1'b1, 40, "R5 carry pattern");
        en = 1'b1;
        drain();

        // R7: disable clears the accumulator, pattern restarts
        en = 1'b0;
        model_acc = 0;
        repeat (3) @(negedge clk);
        #1;
        push_periods(19, 204, 1'b1, 10, "R7 restart pattern");
        en = 1'b1;
        drain();

        // R5: 1024 periods hold exactly div_frac long ones
        set_cfg(2, 204, 1'b1);
        base_len = 2;
        obs_long = 0;
        push_periods(2, 204, 1'b1, 1024, "R5 long run");
        drain();
        check(obs_long == 204, "R5 long count over 1024", obs_long, 204);
        base_len = 0;

        // R9: full scale
        set_cfg(4095, 1023, 1'b1);
        push_periods(4095, 1023, 1'b1, 3, "R9 full scale");
        drain();

        // R4: zero fraction in noise-shaped mode never stretches
        set_cfg(3, 0, 1'b1);
        push_periods(3, 0, 1'b1, 5, "R4 zero fraction");
        drain();

        // R3 with R4: clamped divisor in noise-shaped mode
        set_cfg(1, 512, 1'b1);
        push_periods(1, 512, 1'b1, 6, "R3 clamp noise-shaped");
        drain();

        en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(q_len.size() == 0, "R2 scoreboard empty", q_len.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL R2 watchdog expired: got %0d pending, expected %0d", q_len.size(), 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule